// File: doc/BRIEF.md
# Interrupt Controller Error Status Register

This block holds the error status word of a local interrupt controller. Error events come in as strobes from three places: the send path (checksum, acceptance, redirectable request, illegal vector), the receive path (checksum, acceptance, illegal vector, including locally generated interrupts) and the register-access path (reserved offsets). None of them is visible at once. Every event is merged into a hidden pending accumulator, and software sees a snapshot that changes only when it writes the register.

A software write publishes the accumulator into the visible register and empties the accumulator. It also re-arms a one-shot error interrupt. Software therefore writes first and reads afterwards to learn what went wrong since its previous write. The register port has a mode flag. In legacy memory-mapped mode any write value is accepted, and a reserved offset counts as an error. In extended MSR-style mode only a zero write is accepted, and both a non-zero write and a reserved access raise a protection-fault strobe.

Interrupts that carry an illegal vector (below 16) on the receive or local path are dropped. The block reports this by holding their accept outputs low.

Top module: `ic_errstat`

## Requirements
- R1: The status register decodes at offset 0x280. A read there (reg_valid=1, reg_write=0) returns the visible byte in bits 7:0 and zero in bits 31:8. Any other read returns 0. reg_rdata is combinational from the current request.
- R2: A write accepted at 0x280 copies the pending errors into the visible register, which reg_rdata shows from the next cycle. It also clears the pending errors. The data written has no effect on the value read back. Without such a write the visible register never changes.
- R3: An error event in the same cycle as an accepted write goes into the emptied accumulator. It is not published by that write and appears only after the following write.
- R4: In extended mode (ext_mode=1) only a zero write to 0x280 is accepted. A non-zero write leaves both the visible and the pending errors unchanged. It pulses gp_fault for one cycle, in the cycle after the request.
- R5: Bit 0 is set by a send with snd_cksum_err. Bit 1 is set by a receive with rcv_cksum_err. Bit 2 is set by a send with snd_accept_err. Bit 3 is set by a receive with rcv_accept_err.
- R6: A vector below 16 is illegal. A send with an illegal vector sets bit 5. A receive or local interrupt with an illegal vector sets bit 6 and holds rcv_accept or loc_accept low. Those outputs are high for valid inputs with a legal vector.
- R7: With lowest-priority sending unsupported (the default), a send with snd_lowpri=1 sets only bit 4 (redirectable request), even when its vector is illegal.
- R8: A reserved offset is one of:
  - an offset with bits 3:0 non-zero;
  - an offset below 0x020;
  - an offset from 0x290 to 0x2EF;
  - an offset at or above 0x400.

  In legacy mode a read or write to a reserved offset sets bit 7. In extended mode it sets no bit and pulses gp_fault in the next cycle.
- R9: The error interrupt is armed out of reset and by every accepted write. err_irq pulses for one cycle, in the cycle after the first error event recorded while armed. The block then stays disarmed until the next accepted write. A write and an event in the same cycle count as armed.
- R10: err_present is high exactly when any visible bit is set.
- R11: After reset the visible and pending errors are zero, and err_irq, gp_fault and err_present are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_offset | input | 12 | Byte offset in the controller register space |
| reg_wdata | input | 32 | Write data |
| ext_mode | input | 1 | 1 = extended MSR-style access, 0 = legacy memory-mapped |
| reg_rdata | output | 32 | Read data |
| snd_valid | input | 1 | Outgoing message strobe |
| snd_vector | input | 8 | Outgoing vector |
| snd_lowpri | input | 1 | Outgoing message uses lowest-priority delivery |
| snd_cksum_err | input | 1 | Checksum error on outgoing message |
| snd_accept_err | input | 1 | Outgoing message not accepted |
| rcv_valid | input | 1 | Incoming message strobe |
| rcv_vector | input | 8 | Incoming vector |
| rcv_cksum_err | input | 1 | Checksum error on incoming message |
| rcv_accept_err | input | 1 | Incoming message not accepted |
| loc_valid | input | 1 | Locally generated interrupt strobe |
| loc_vector | input | 8 | Local interrupt vector |
| rcv_accept | output | 1 | Incoming interrupt may be delivered |
| loc_accept | output | 1 | Local interrupt may be delivered |
| err_irq | output | 1 | One-cycle error interrupt request |
| gp_fault | output | 1 | One-cycle protection-fault strobe |
| err_present | output | 1 | Visible register holds an error |

## Verification
The accumulator is hidden, so most internal errors are seen late. A bit dropped from or wrongly merged into the accumulator stays invisible until the next accepted write. It then shows as a wrong read value and a wrong err_present one cycle later. An arming flag stuck high or low shows sooner: a missing or repeated err_irq pulse appears in the cycle after the next error event. A wrong mode or offset decode shows as a gp_fault pulse that is missing or extra one cycle after the access, or as a stray bit 7 after the next write.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
   localparam int SLOT_W = 8;
   localparam int ADDR_W = SLOT_W + 4;
   localparam int SLOTS  = 2 ** SLOT_W;
   localparam int NBITS  = 8;

   localparam int B_SND_CK  = 0;
   localparam int B_RCV_CK  = 1;
   localparam int B_SND_ACC = 2;
   localparam int B_RCV_ACC = 3;
   localparam int B_REDIR   = 4;
   localparam int B_SND_ILL = 5;
   localparam int B_RCV_ILL = 6;
   localparam int B_ACCESS  = 7;

   typedef logic [NBITS-1:0] err_bits_t;

   function automatic logic [SLOTS-1:0] default_rsvd_map();
      logic [SLOTS-1:0] m;
      for (int i = 0; i < SLOTS; i++)
         m[i] = (i < 2) || (i >= 'h29 && i <= 'h2E) || (i >= 'h40);
      return m;
   endfunction
endpackage

// File: rtl/errstat_decode.sv
module errstat_decode
   import errstat_pkg::*;
#(
   parameter int                  DATA_W     = 32,
   parameter logic [ADDR_W-1:0]   REG_OFFSET = 12'h280,
   parameter logic [SLOTS-1:0]    RSVD_MAP   = default_rsvd_map()
) (
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_offset,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              ext_mode,
   output logic              hit_rd,
   output logic              wr_ok,
   output logic              rsvd_evt,
   output logic              gp_evt
);
   logic hit, rsvd, bad_ext_wr;

   assign hit        = (reg_offset == REG_OFFSET);
   assign rsvd       = (reg_offset[3:0] != 4'h0) || RSVD_MAP[reg_offset[ADDR_W-1:4]];
   assign bad_ext_wr = reg_write && hit && (reg_wdata != '0);

   assign hit_rd   = reg_valid && !reg_write && hit;
   assign wr_ok    = reg_valid && reg_write && hit && !(ext_mode && bad_ext_wr);
   assign rsvd_evt = reg_valid && !ext_mode && rsvd;
   assign gp_evt   = reg_valid && ext_mode && (rsvd || bad_ext_wr);
endmodule

// File: rtl/errstat_evtmap.sv
module errstat_evtmap
   import errstat_pkg::*;
#(
   parameter int VEC_W         = 8,
   parameter int ILLEGAL_LIMIT = 16,
   parameter bit LOWPRI_OK     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_valid,
   input  logic [VEC_W-1:0] snd_vector,
   input  logic             snd_lowpri,
   input  logic             snd_cksum_err,
   input  logic             snd_accept_err,
   input  logic             rcv_valid,
   input  logic [VEC_W-1:0] rcv_vector,
   input  logic             rcv_cksum_err,
   input  logic             rcv_accept_err,
   input  logic             loc_valid,
   input  logic [VEC_W-1:0] loc_vector,
   input  logic             rsvd_evt,
   output err_bits_t        evt_o,
   output logic             rcv_accept,
   output logic             loc_accept
);
   localparam logic [VEC_W-1:0] LIM = VEC_W'(ILLEGAL_LIMIT);

   logic snd_bad, rcv_bad, loc_bad, redir, snd_ill;

   assign snd_bad = snd_vector < LIM;
   assign rcv_bad = rcv_vector < LIM;
   assign loc_bad = loc_vector < LIM;

   generate
      if (LOWPRI_OK) begin : g_lowpri_sent
         assign redir   = 1'b0;
         assign snd_ill = snd_valid && snd_bad;
      end else begin : g_lowpri_redirect
         assign redir   = snd_valid && snd_lowpri;
         assign snd_ill = snd_valid && snd_bad && !snd_lowpri;
      end
   endgenerate

   always_comb begin
      evt_o            = '0;
      evt_o[B_SND_CK]  = snd_valid && snd_cksum_err;
      evt_o[B_RCV_CK]  = rcv_valid && rcv_cksum_err;
      evt_o[B_SND_ACC] = snd_valid && snd_accept_err;
      evt_o[B_RCV_ACC] = rcv_valid && rcv_accept_err;
      evt_o[B_REDIR]   = redir;
      evt_o[B_SND_ILL] = snd_ill;
      evt_o[B_RCV_ILL] = (rcv_valid && rcv_bad) || (loc_valid && loc_bad);
      evt_o[B_ACCESS]  = rsvd_evt;
   end

   assign rcv_accept = rcv_valid && !rcv_bad;
   assign loc_accept = loc_valid && !loc_bad;

   // R7
   redir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_o[B_REDIR] && evt_o[B_SND_ILL]));
   // R6
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_accept || loc_accept) |-> !(rcv_accept && rcv_bad) && !(loc_accept && loc_bad));
endmodule

// File: rtl/errstat_accum.sv
module errstat_accum
   import errstat_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_i,
   input  err_bits_t evt_i,
   output err_bits_t vis_o,
   output logic      irq_o
);
   err_bits_t pend_q, vis_q;
   logic      armed_q, irq_q, any;

   assign any = (evt_i != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         vis_q   <= '0;
         armed_q <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         if (wr_i) begin
            vis_q  <= pend_q;
            pend_q <= evt_i;
         end else begin
            pend_q <= pend_q | evt_i;
         end
         irq_q   <= any && (armed_q || wr_i);
         armed_q <= wr_i ? !any : (armed_q && !any);
      end
   end

   assign vis_o = vis_q;
   assign irq_o = irq_q;

   // R2
   vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(vis_q));
   // R3
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (pend_q == $past(evt_i)));
endmodule

// File: rtl/ic_errstat.sv
module ic_errstat
   import errstat_pkg::*;
#(
   parameter int                DATA_W        = 32,
   parameter int                VEC_W         = 8,
   parameter int                ILLEGAL_LIMIT = 16,
   parameter bit                LOWPRI_OK     = 1'b0,
   parameter logic [ADDR_W-1:0] REG_OFFSET    = 12'h280,
   parameter logic [SLOTS-1:0]  RSVD_MAP      = default_rsvd_map()
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_offset,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              ext_mode,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              snd_valid,
   input  logic [VEC_W-1:0]  snd_vector,
   input  logic              snd_lowpri,
   input  logic              snd_cksum_err,
   input  logic              snd_accept_err,
   input  logic              rcv_valid,
   input  logic [VEC_W-1:0]  rcv_vector,
   input  logic              rcv_cksum_err,
   input  logic              rcv_accept_err,
   input  logic              loc_valid,
   input  logic [VEC_W-1:0]  loc_vector,
   output logic              rcv_accept,
   output logic              loc_accept,
   output logic              err_irq,
   output logic              gp_fault,
   output logic              err_present
);
   generate
      if (DATA_W < NBITS) begin : g_bad_width
         $error("ic_errstat: DATA_W must hold the status bits");
      end
      if (ILLEGAL_LIMIT >= 2 ** VEC_W) begin : g_bad_limit
         $error("ic_errstat: ILLEGAL_LIMIT exceeds vector range");
      end
      if (REG_OFFSET[3:0] != 4'h0) begin : g_bad_offset
         $error("ic_errstat: REG_OFFSET must be 16-byte aligned");
      end
   endgenerate

   logic      hit_rd, wr_ok, rsvd_evt, gp_evt, gp_q;
   err_bits_t evt, vis;

   errstat_decode #(
      .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET), .RSVD_MAP(RSVD_MAP)
   ) u_dec (
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_offset(reg_offset),
      .reg_wdata(reg_wdata), .ext_mode(ext_mode), .hit_rd(hit_rd),
      .wr_ok(wr_ok), .rsvd_evt(rsvd_evt), .gp_evt(gp_evt)
   );

   errstat_evtmap #(
      .VEC_W(VEC_W), .ILLEGAL_LIMIT(ILLEGAL_LIMIT), .LOWPRI_OK(LOWPRI_OK)
   ) u_map (
      .clk(clk), .rst_n(rst_n),
      .snd_valid(snd_valid), .snd_vector(snd_vector), .snd_lowpri(snd_lowpri),
      .snd_cksum_err(snd_cksum_err), .snd_accept_err(snd_accept_err),
      .rcv_valid(rcv_valid), .rcv_vector(rcv_vector),
      .rcv_cksum_err(rcv_cksum_err), .rcv_accept_err(rcv_accept_err),
      .loc_valid(loc_valid), .loc_vector(loc_vector), .rsvd_evt(rsvd_evt),
      .evt_o(evt), .rcv_accept(rcv_accept), .loc_accept(loc_accept)
   );

   errstat_accum u_acc (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ok), .evt_i(evt),
      .vis_o(vis), .irq_o(err_irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) gp_q <= 1'b0;
      else        gp_q <= gp_evt;
   end

   assign gp_fault    = gp_q;
   assign err_present = (vis != '0);
   assign reg_rdata   = hit_rd ? {{(DATA_W-NBITS){1'b0}}, vis} : '0;

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> $past(evt != '0));
   // R10
   present_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_present) |-> $past(wr_ok));
   // R4
   gp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $past(ext_mode && reg_valid));
   // R8
   legacy_no_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !ext_mode) |=> !gp_fault);
endmodule

// File: tb/ic_errstat_tb.sv
module ic_errstat_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 0, reg_write = 0, ext_mode = 0;
   logic [11:0] reg_offset = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        snd_valid = 0, snd_lowpri = 0, snd_cksum_err = 0, snd_accept_err = 0;
   logic [7:0]  snd_vector = 8'h40, rcv_vector = 8'h40, loc_vector = 8'h40;
   logic        rcv_valid = 0, rcv_cksum_err = 0, rcv_accept_err = 0, loc_valid = 0;
   logic        rcv_accept, loc_accept, err_irq, gp_fault, err_present;

   always #5 clk = ~clk;

   ic_errstat u_dut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_offset(reg_offset), .reg_wdata(reg_wdata), .ext_mode(ext_mode),
      .reg_rdata(reg_rdata), .snd_valid(snd_valid), .snd_vector(snd_vector),
      .snd_lowpri(snd_lowpri), .snd_cksum_err(snd_cksum_err),
      .snd_accept_err(snd_accept_err), .rcv_valid(rcv_valid),
      .rcv_vector(rcv_vector), .rcv_cksum_err(rcv_cksum_err),
      .rcv_accept_err(rcv_accept_err), .loc_valid(loc_valid),
      .loc_vector(loc_vector), .rcv_accept(rcv_accept), .loc_accept(loc_accept),
      .err_irq(err_irq), .gp_fault(gp_fault), .err_present(err_present)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   // reference state
   int m_pend = 0, m_vis = 0;
   bit m_armed = 1, m_irq = 0, m_gp = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit reserved(logic [11:0] off);
      int s = int'(off[11:4]);
      return (off[3:0] != 0) || s < 2 || (s >= 'h29 && s <= 'h2E) || s >= 'h40;
   endfunction

   function automatic int events_now();
      int e = 0;
      if (snd_valid) begin
         if (snd_cksum_err)  e |= 'h01;
         if (snd_accept_err) e |= 'h04;
         if (snd_lowpri)     e |= 'h10;
         else if (snd_vector < 16) e |= 'h20;
      end
      if (rcv_valid) begin
         if (rcv_cksum_err)  e |= 'h02;
         if (rcv_accept_err) e |= 'h08;
         if (rcv_vector < 16) e |= 'h40;
      end
      if (loc_valid && loc_vector < 16) e |= 'h40;
      if (reg_valid && !ext_mode && reserved(reg_offset)) e |= 'h80;
      return e;
   endfunction

   function automatic bit accepted_write();
      if (!(reg_valid && reg_write && reg_offset == 12'h280)) return 0;
      return !ext_mode || reg_wdata == 0;
   endfunction

   function automatic bit fault_now();
      if (!(reg_valid && ext_mode)) return 0;
      return reserved(reg_offset) || (reg_write && reg_offset == 12'h280 && reg_wdata != 0);
   endfunction

   task automatic step();
      int  e;
      bit  w;
      int  exp_rd;
      #1;
      exp_rd = (reg_valid && !reg_write && reg_offset == 12'h280) ? m_vis : 0;
      chk("R1 rdata", reg_rdata, exp_rd);
      chk("R6 rcv_accept", rcv_accept, rcv_valid && rcv_vector >= 16);
      chk("R6 loc_accept", loc_accept, loc_valid && loc_vector >= 16);
      @(posedge clk);
      e = events_now();
      w = accepted_write();
      m_gp = fault_now();
      if (e != 0 && (m_armed || w)) m_irq = 1; else m_irq = 0;
      if (w) begin
         m_vis = m_pend;
         m_pend = e;
         m_armed = (e == 0);
      end else begin
         m_pend = m_pend | e;
         if (e != 0) m_armed = 0;
      end
      @(negedge clk);
      chk("R9 err_irq", err_irq, m_irq);
      chk("R4/R8 gp_fault", gp_fault, m_gp);
      chk("R10 err_present", err_present, m_vis != 0);
   endtask

   task automatic idle();
      reg_valid = 0; reg_write = 0; reg_offset = 0; reg_wdata = 0; ext_mode = 0;
      snd_valid = 0; snd_lowpri = 0; snd_cksum_err = 0; snd_accept_err = 0;
      rcv_valid = 0; rcv_cksum_err = 0; rcv_accept_err = 0; loc_valid = 0;
      snd_vector = 8'h40; rcv_vector = 8'h40; loc_vector = 8'h40;
   endtask

   task automatic sw_write(logic [31:0] d, logic ext);
      reg_valid = 1; reg_write = 1; reg_offset = 12'h280; reg_wdata = d; ext_mode = ext;
      step();
      idle();
   endtask

   task automatic sw_read(string tag, int exp);
      reg_valid = 1; reg_write = 0; reg_offset = 12'h280; ext_mode = 0;
      #1;
      chk(tag, reg_rdata, exp);
      step();
      idle();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 err_irq", err_irq, 0);
      chk("R11 gp_fault", gp_fault, 0);
      chk("R11 err_present", err_present, 0);
      rst_n = 1;
      sw_read("R11 visible zero", 0);
      // R5 R9: event without write stays hidden, irq pulses once
      snd_valid = 1; snd_cksum_err = 1; step(); idle();
      chk("R9 pulse after first event", err_irq, 1);
      step();
      chk("R9 pulse one cycle", err_irq, 0);
      sw_read("R2 hidden until write", 0);
      rcv_valid = 1; rcv_cksum_err = 1; rcv_accept_err = 1; step(); idle();
      chk("R9 disarmed", err_irq, 0);
      snd_valid = 1; snd_accept_err = 1; step(); idle();
      sw_write(32'h0000_005A, 0);
      sw_read("R5 bits 0..3", 'h0F);
      chk("R10 present", err_present, 1);
      // R3: event same cycle as write
      reg_valid = 1; reg_write = 1; reg_offset = 12'h280; reg_wdata = 32'hFFFF_FFFF;
      snd_valid = 1; snd_vector = 8'd5;
      step(); idle();
      chk("R9 irq on write+event", err_irq, 1);
      sw_read("R3 old pending published", 0);
      chk("R10 present low", err_present, 0);
      sw_write(0, 0);
      sw_read("R6 send illegal bit5", 'h20);
      // R6 receive/local illegal dropped
      rcv_valid = 1; rcv_vector = 8'd3; #1;
      chk("R6 rcv dropped", rcv_accept, 0);
      step(); idle();
      loc_valid = 1; loc_vector = 8'd15; #1;
      chk("R6 loc dropped", loc_accept, 0);
      step(); idle();
      rcv_valid = 1; rcv_vector = 8'd16; #1;
      chk("R6 vector 16 legal", rcv_accept, 1);
      step(); idle();
      sw_write(0, 1);
      sw_read("R6 receive illegal bit6", 'h40);
      // R7
      snd_valid = 1; snd_lowpri = 1; snd_vector = 8'd2; step(); idle();
      sw_write(1, 0);
      sw_read("R7 only redirect bit", 'h10);
      // R8 legacy then extended reserved
      reg_valid = 1; reg_offset = 12'h290; step(); idle();
      chk("R8 legacy no fault", gp_fault, 0);
      reg_valid = 1; reg_offset = 12'h290; ext_mode = 1; step(); idle();
      chk("R8 extended fault", gp_fault, 1);
      sw_write(0, 0);
      sw_read("R8 access bit only from legacy", 'h80);
      // R4 non-zero extended write ignored
      snd_valid = 1; snd_accept_err = 1; step(); idle();
      sw_write(32'h1, 1);
      chk("R4 fault on nonzero write", gp_fault, 1);
      sw_read("R4 visible unchanged", 'h80);
      sw_write(0, 1);
      sw_read("R4 zero write accepted", 'h04);
      // mixed traffic
      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 9);
         reg_valid = (r < 4);
         reg_write = $urandom_range(0, 1);
         ext_mode  = $urandom_range(0, 1);
         case ($urandom_range(0, 5))
            0, 1: reg_offset = 12'h280;
            2: reg_offset = 12'h281;
            3: reg_offset = 12'h2A0;
            4: reg_offset = 12'h800;
            default: reg_offset = 12'h300;
         endcase
         reg_wdata = $urandom_range(0, 1) ? 32'h0 : $urandom;
         snd_valid = ($urandom_range(0, 4) == 0);
         snd_vector = 8'($urandom_range(0, 40));
         snd_lowpri = ($urandom_range(0, 3) == 0);
         snd_cksum_err = ($urandom_range(0, 5) == 0);
         snd_accept_err = ($urandom_range(0, 5) == 0);
         rcv_valid = ($urandom_range(0, 4) == 0);
         rcv_vector = 8'($urandom_range(0, 40));
         rcv_cksum_err = ($urandom_range(0, 5) == 0);
         rcv_accept_err = ($urandom_range(0, 5) == 0);
         loc_valid = ($urandom_range(0, 5) == 0);
         loc_vector = 8'($urandom_range(0, 40));
         step();
      end
      idle();
      step();
      summary();
   end
endmodule